// File: doc/BRIEF.md
# Bridge Bus Error Logger with First/Next Fatal Capture

This block collects the error events that the parallel side of a bus bridge reports and turns them into two things: a log that software can read, and a request for an uncorrectable error message toward the serial link. The four event inputs are pulses: target abort, master abort, data parity error and address/attribute parity error. Each pulse comes with the descriptor of the transaction concerned, which gives its address, command and attributes. The two abort events are non-fatal. The two parity events are fatal, because they can corrupt data.

The log has two tiers for fatal errors. The first fatal error sets a status bit and loads the transaction descriptor. The log then stays frozen, and each later fatal error only sets a second status bit. A non-fatal error may fill an empty log, and a fatal error that follows may replace it. Software clears the status bits with write-one-to-clear strobes. Clearing the first-error bit also empties the log, so the next fatal error is captured afresh. A configuration input masks the message requests of each class separately; the mask does not affect logging.

Top module: `bus_err_logger`

## Requirements
- R1: After reset, first_fatal, next_fatal, log_valid, log_fatal, msg_req and msg_fatal are all 0.
- R2: A pulse on err_dpar or err_apar is fatal and a pulse on err_tabort or err_mabort is non-fatal. One clock after the event cycle, msg_req is 1 for exactly one cycle, and msg_fatal is 1 for a fatal event and 0 for a non-fatal one. No message is ever correctable.
- R3: A fatal event while first_fatal is 0 sets first_fatal, log_valid and log_fatal on the next edge and loads log_addr, log_cmd and log_attr from the transaction inputs.
- R4: A fatal event while first_fatal is 1 sets next_fatal and leaves log_addr, log_cmd, log_attr and log_fatal unchanged.
- R5: A non-fatal event never sets next_fatal. It loads the log with log_fatal = 0 only when log_valid is 0, and it never overwrites a valid log.
- R6: A fatal event while the log holds a non-fatal entry (log_valid = 1, log_fatal = 0) overwrites the log and sets first_fatal.
- R7: A clr_first pulse clears first_fatal and log_valid. A clr_next pulse clears only next_fatal. After clr_first, the next fatal event is captured as a new first error.
- R8: When a fatal and a non-fatal event arrive in the same cycle, the fatal event is logged and the message has msg_fatal = 1.
- R9: An event in the same cycle as a clear strobe is applied after the clear. For example, a fatal event together with clr_first loads the new transaction and leaves first_fatal at 1.
- R10: mask_fatal = 1 suppresses message requests for fatal events, and mask_nonfatal = 1 suppresses them for non-fatal events. Logging is unchanged by either mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_tabort | input | 1 | Target abort event pulse |
| err_mabort | input | 1 | Master abort event pulse |
| err_dpar | input | 1 | Data parity error event pulse |
| err_apar | input | 1 | Address/attribute parity error event pulse |
| txn_addr | input | ADDR_W | Address of the transaction concerned |
| txn_cmd | input | CMD_W | Bus command of the transaction |
| txn_attr | input | ATTR_W | Attributes of the transaction |
| clr_first | input | 1 | Write-one-to-clear strobe for the first-error bit and log |
| clr_next | input | 1 | Write-one-to-clear strobe for the next-error bit |
| mask_fatal | input | 1 | Suppress message requests for fatal events |
| mask_nonfatal | input | 1 | Suppress message requests for non-fatal events |
| first_fatal | output | 1 | First fatal error captured |
| next_fatal | output | 1 | A further fatal error occurred while frozen |
| log_valid | output | 1 | Transaction log holds an entry |
| log_fatal | output | 1 | Logged entry type: 1 fatal, 0 non-fatal |
| log_addr | output | ADDR_W | Logged address |
| log_cmd | output | CMD_W | Logged command |
| log_attr | output | ATTR_W | Logged attributes |
| msg_req | output | 1 | One-cycle uncorrectable message request |
| msg_fatal | output | 1 | Severity of the request: 1 fatal, 0 non-fatal |

## Verification
A wrong freeze state appears at the ports within one edge. A second fatal error then changes log_addr where it should set next_fatal, or a non-fatal error replaces a fatal entry. A wrong classification or mask decode shows on msg_req or msg_fatal in the cycle after the event. The sweep covers every combination of the four event inputs under every mask setting, starting from an empty log. Each combination is followed by a fatal event, so that both the frozen case and the overwrite case are checked.

// File: rtl/bus_err_logger.sv
module bus_err_logger #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_tabort,
  input  logic              err_mabort,
  input  logic              err_dpar,
  input  logic              err_apar,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [CMD_W-1:0]  txn_cmd,
  input  logic [ATTR_W-1:0] txn_attr,
  input  logic              clr_first,
  input  logic              clr_next,
  input  logic              mask_fatal,
  input  logic              mask_nonfatal,
  output logic              first_fatal,
  output logic              next_fatal,
  output logic              log_valid,
  output logic              log_fatal,
  output logic [ADDR_W-1:0] log_addr,
  output logic [CMD_W-1:0]  log_cmd,
  output logic [ATTR_W-1:0] log_attr,
  output logic              msg_req,
  output logic              msg_fatal
);

  logic fatal_ev, nf_ev, first_c, next_c, valid_c, load;

  assign fatal_ev = err_dpar | err_apar;
  assign nf_ev    = err_tabort | err_mabort;

  // clears apply first, then the new event
  assign first_c = first_fatal & ~clr_first;
  assign next_c  = next_fatal & ~clr_next;
  assign valid_c = log_valid & ~clr_first;
  assign load    = (fatal_ev & ~first_c) | (~fatal_ev & nf_ev & ~valid_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_fatal <= 1'b0;
      next_fatal  <= 1'b0;
      log_valid   <= 1'b0;
      log_fatal   <= 1'b0;
      msg_req     <= 1'b0;
      msg_fatal   <= 1'b0;
    end else begin
      first_fatal <= first_c | fatal_ev;
      next_fatal  <= next_c | (fatal_ev & first_c);
      log_valid   <= valid_c | load;
      if (load) log_fatal <= fatal_ev;
      msg_req     <= (fatal_ev & ~mask_fatal) | (nf_ev & ~mask_nonfatal);
      msg_fatal   <= fatal_ev & ~mask_fatal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_addr <= '0;
      log_cmd  <= '0;
      log_attr <= '0;
    end else if (load) begin
      log_addr <= txn_addr;
      log_cmd  <= txn_cmd;
      log_attr <= txn_attr;
    end
  end

  // R3
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_ev && !first_fatal) |=> (first_fatal && log_valid && log_fatal));

  // R4
  frozen_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_fatal && !clr_first) |=> ($stable(log_addr) && $stable(log_cmd) && $stable(log_attr) && log_fatal));

  // R5
  nonfatal_no_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!next_fatal && !fatal_ev) |=> !next_fatal);

  // R5
  nonfatal_keeps_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !clr_first && !fatal_ev) |=> ($stable(log_addr) && $stable(log_fatal)));

  // R2
  fatal_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_ev && !mask_fatal) |=> (msg_req && msg_fatal));

  // R10
  masked_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fatal_ev || mask_fatal) && (!nf_ev || mask_nonfatal)) |=> !msg_req);

  // R2
  severity_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fatal |-> msg_req);

  // R6
  fatal_type_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_fatal |-> (log_valid && log_fatal));

endmodule

// File: tb/test_bus_err_logger.sv
module test_bus_err_logger;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, CW = 4, TW = 4;

  logic clk = 0, rst_n = 0;
  logic ta = 0, ma = 0, dp = 0, ap = 0, cf = 0, cn = 0, mf = 0, mn = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] cmd = '0;
  logic [TW-1:0] attr = '0;
  logic first_fatal, next_fatal, log_valid, log_fatal, msg_req, msg_fatal;
  logic [AW-1:0] log_addr;
  logic [CW-1:0] log_cmd;
  logic [TW-1:0] log_attr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_logger #(.ADDR_W(AW), .CMD_W(CW), .ATTR_W(TW)) i_bus_err_logger (
    .clk(clk), .rst_n(rst_n), .err_tabort(ta), .err_mabort(ma), .err_dpar(dp),
    .err_apar(ap), .txn_addr(addr), .txn_cmd(cmd), .txn_attr(attr),
    .clr_first(cf), .clr_next(cn), .mask_fatal(mf), .mask_nonfatal(mn),
    .first_fatal(first_fatal), .next_fatal(next_fatal), .log_valid(log_valid),
    .log_fatal(log_fatal), .log_addr(log_addr), .log_cmd(log_cmd),
    .log_attr(log_attr), .msg_req(msg_req), .msg_fatal(msg_fatal));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, sample just after the capturing edge
  task automatic step(logic [3:0] ev, logic c1, logic c2, logic [AW-1:0] a);
    @(negedge clk);
    {ta, ma, dp, ap} = ev; cf = c1; cn = c2;
    addr = a; cmd = a[CW-1:0]; attr = a[TW+3:4];
    @(posedge clk); #1;
    {ta, ma, dp, ap} = 4'b0; cf = 0; cn = 0;
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 first", first_fatal, 0); check("R1 next", next_fatal, 0);
    check("R1 valid", log_valid, 0);   check("R1 type", log_fatal, 0);
    check("R1 req", msg_req, 0);       check("R1 sev", msg_fatal, 0);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 16; e++) begin
        logic isf, isn;
        logic [AW-1:0] a1, a2;
        isf = e[1] | e[0];
        isn = e[3] | e[2];
        a1 = AW'(16'h1000 + e*16 + m);
        a2 = AW'(16'h8000 + e);
        mf = m[0]; mn = m[1];
        step(4'b0, 1, 1, '0);
        step(e[3:0], 0, 0, a1);
        // R2 R8 R10
        check("R2 req", msg_req, (isf & ~mf) | (isn & ~mn));
        check("R8 sev", msg_fatal, isf & ~mf);
        // R3 R5 R8 R10
        check("R3 first", first_fatal, isf);
        check("R5 next", next_fatal, 0);
        check("R5 valid", log_valid, isf | isn);
        if (isf | isn) begin
          check("R3 type", log_fatal, isf);
          check("R3 addr", log_addr, a1);
          check("R3 cmd", log_cmd, a1[CW-1:0]);
        end
        step(4'b0, 0, 0, '0);
        check("R2 pulse", msg_req, 0);
        // follow with a fatal event: frozen (R4) or overwrite (R6)
        step(4'b0010, 0, 0, a2);
        check("R4 next", next_fatal, isf);
        check("R6 first", first_fatal, 1);
        check("R6 type", log_fatal, 1);
        check("R4 addr", log_addr, isf ? a1 : a2);
        check("R4 attr", log_attr, isf ? a1[TW+3:4] : a2[TW+3:4]);
      end
    end
    mf = 0; mn = 0;

    // R5: non-fatal never overwrites a non-fatal log, never sets next
    step(4'b0, 1, 1, '0);
    step(4'b1000, 0, 0, 16'h0AA0);
    step(4'b0100, 0, 0, 16'h0BB0);
    check("R5 keep", log_addr, 16'h0AA0);
    check("R5 next", next_fatal, 0);
    // R7: clr_next alone
    step(4'b0001, 0, 0, 16'h0CC0);
    step(4'b0001, 0, 0, 16'h0DD0);
    check("R7 set", next_fatal, 1);
    step(4'b0, 0, 1, '0);
    check("R7 next clr", next_fatal, 0);
    check("R7 first kept", first_fatal, 1);
    check("R7 log kept", log_addr, 16'h0CC0);
    // R7: clr_first empties, new fatal is fresh first
    step(4'b0, 1, 0, '0);
    check("R7 first clr", first_fatal, 0);
    check("R7 valid clr", log_valid, 0);
    step(4'b0010, 0, 0, 16'h0EE0);
    check("R7 recapture", log_addr, 16'h0EE0);
    check("R7 no next", next_fatal, 0);
    // R9: event together with clear
    step(4'b0001, 1, 0, 16'h0FF0);
    check("R9 first", first_fatal, 1);
    check("R9 addr", log_addr, 16'h0FF0);
    check("R9 next", next_fatal, 0);
    step(4'b0010, 0, 1, 16'h0123);
    check("R9 next set", next_fatal, 1);
    check("R9 frozen", log_addr, 16'h0FF0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule